// File: doc/BRIEF.md
# Power-Management SMI and Reset Control

This block takes a handful of register writes from a chipset configuration path and turns them into system-level events. A one-byte reset control register either records which kind of reset software wants or, when its go bit is written, fires a system reset request. The power-management command port decodes two command values that switch the SCI enable state on or off. Every other command value raises a system management interrupt (SMI), but only if the command-port SMI enable bit is set.

A lock bit in the general power-management configuration word freezes itself and the global SMI enable bit once it is set, and both stay frozen until reset. The block also holds the power-management I/O base register. It accepts byte-enabled writes and presents the base through a fixed address mask.

Top module: `pm_smi_rst_ctrl`

## Requirements
- R1: A reset control write with bit 2 set raises `sys_rst_req` for exactly the following cycle and leaves `rstc_rdata` unchanged.
- R2: A reset control write with bit 2 clear stores only bits 3 and 1 of the data (mask 8'h0A); every other bit of `rstc_rdata` reads as zero.
- R3: While `rst_n` is low, all stored registers, `sci_en` and every pulse output are zero.
- R4: A command write equal to `ACPI_ON_CODE` sets `sci_en` and pulses `acpi_on_stb` in the next cycle. A write equal to `ACPI_OFF_CODE` clears `sci_en` and pulses `acpi_off_stb`. Neither produces an SMI.
- R5: A command write of any other value pulses `smi_pulse` in the next cycle if and only if bit `APMC_BIT` of the stored SMI enable register is set before that write.
- R6: Once bit `LOCK_BIT` of the configuration word is 1, writes cannot clear it. Bit 0 of the SMI enable register then ignores writes until reset. All other bits of both registers stay writable.
- R7: Each byte of the I/O base register updates only when its byte enable is set. `pmbase` equals the stored value ANDed with `BASE_MASK`.
- R8: Each command write yields at most one cycle of `smi_pulse`. Back-to-back qualifying writes yield back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rstc_wr | input | 1 | Reset control write strobe |
| rstc_wdata | input | 8 | Reset control write data |
| rstc_rdata | output | 8 | Stored reset control value |
| sys_rst_req | output | 1 | One-cycle system reset request |
| apm_wr | input | 1 | Command port write strobe |
| apm_wdata | input | 8 | Command value |
| smien_wr | input | 1 | SMI enable register write strobe |
| smien_wdata | input | SMIEN_W | SMI enable write data |
| smien_rdata | output | SMIEN_W | Stored SMI enable value |
| pmcon_wr | input | 1 | Configuration word write strobe |
| pmcon_wdata | input | PMCON_W | Configuration word write data |
| pmcon_rdata | output | PMCON_W | Stored configuration word |
| pmbase_be | input | BASE_W/8 | I/O base byte enables (zero means no write) |
| pmbase_wdata | input | BASE_W | I/O base write data |
| pmbase | output | BASE_W | Masked I/O base |
| smi_pulse | output | 1 | One-cycle SMI request |
| sci_en | output | 1 | SCI enable state |
| acpi_on_stb | output | 1 | One-cycle strobe on the enable command |
| acpi_off_stb | output | 1 | One-cycle strobe on the disable command |

## Verification
The bench overrides the two command codes with 8'h96 and 8'h69. Decoding that only works because the default values happen to match would therefore show up, and the default codes 8'hF0/8'hF1 become ordinary commands that must raise an SMI. The other parameters keep their defaults: lock at bit 4, command SMI enable at bit 5, a 32-bit base with mask 32'h0000FF80. At these values a full-width write of ones to the SMI enable register hits both the frozen bit 0 and the command enable bit. A mid-run reset after locking shows that the freeze lifts.

// File: rtl/pm_smi_rst_ctrl.sv
module pm_smi_rst_ctrl #(
  parameter logic [7:0] ACPI_ON_CODE  = 8'hF0,
  parameter logic [7:0] ACPI_OFF_CODE = 8'hF1,
  parameter int SMIEN_W  = 32,
  parameter int APMC_BIT = 5,
  parameter int PMCON_W  = 16,
  parameter int LOCK_BIT = 4,
  parameter int BASE_W   = 32,
  parameter logic [BASE_W-1:0] BASE_MASK = 32'h0000_FF80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rstc_wr,
  input  logic [7:0]           rstc_wdata,
  output logic [7:0]           rstc_rdata,
  output logic                 sys_rst_req,
  input  logic                 apm_wr,
  input  logic [7:0]           apm_wdata,
  input  logic                 smien_wr,
  input  logic [SMIEN_W-1:0]   smien_wdata,
  output logic [SMIEN_W-1:0]   smien_rdata,
  input  logic                 pmcon_wr,
  input  logic [PMCON_W-1:0]   pmcon_wdata,
  output logic [PMCON_W-1:0]   pmcon_rdata,
  input  logic [BASE_W/8-1:0]  pmbase_be,
  input  logic [BASE_W-1:0]    pmbase_wdata,
  output logic [BASE_W-1:0]    pmbase,
  output logic                 smi_pulse,
  output logic                 sci_en,
  output logic                 acpi_on_stb,
  output logic                 acpi_off_stb
);
  localparam int NBYTES = BASE_W / 8;
  localparam int GO_BIT = 2;
  localparam logic [7:0] KEEP = 8'h0A;
  localparam logic [PMCON_W-1:0] LOCK_ONE = PMCON_W'(1) << LOCK_BIT;

  logic [7:0]         rstc_q;
  logic [SMIEN_W-1:0] smien_q;
  logic [PMCON_W-1:0] pmcon_q;
  logic [BASE_W-1:0]  base_q;
  logic rst_req_q, smi_q, sci_q, on_q, off_q;

  wire locked  = pmcon_q[LOCK_BIT];
  wire cmd_on  = apm_wr && (apm_wdata == ACPI_ON_CODE);
  wire cmd_off = apm_wr && (apm_wdata == ACPI_OFF_CODE);
  wire cmd_smi = apm_wr && !cmd_on && !cmd_off && smien_q[APMC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstc_q    <= '0;
      rst_req_q <= 1'b0;
      smien_q   <= '0;
      pmcon_q   <= '0;
      smi_q     <= 1'b0;
      sci_q     <= 1'b0;
      on_q      <= 1'b0;
      off_q     <= 1'b0;
    end else begin
      rst_req_q <= rstc_wr && rstc_wdata[GO_BIT];
      if (rstc_wr && !rstc_wdata[GO_BIT])
        rstc_q <= rstc_wdata & KEEP;
      on_q  <= cmd_on;
      off_q <= cmd_off;
      smi_q <= cmd_smi;
      if (cmd_on)
        sci_q <= 1'b1;
      else if (cmd_off)
        sci_q <= 1'b0;
      if (smien_wr)
        smien_q <= locked ? {smien_wdata[SMIEN_W-1:1], smien_q[0]} : smien_wdata;
      if (pmcon_wr)
        pmcon_q <= locked ? (pmcon_wdata | LOCK_ONE) : pmcon_wdata;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_base_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base_q[8*b +: 8] <= '0;
      else if (pmbase_be[b])
        base_q[8*b +: 8] <= pmbase_wdata[8*b +: 8];
    end
  end

  assign rstc_rdata   = rstc_q;
  assign sys_rst_req  = rst_req_q;
  assign smien_rdata  = smien_q;
  assign pmcon_rdata  = pmcon_q;
  assign pmbase       = base_q & BASE_MASK;
  assign smi_pulse    = smi_q;
  assign sci_en       = sci_q;
  assign acpi_on_stb  = on_q;
  assign acpi_off_stb = off_q;

  // R1
  reset_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rstc_wr && rstc_wdata[GO_BIT]) |=> (sys_rst_req && $stable(rstc_rdata)));

  // R2
  reset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rstc_wr && !rstc_wdata[GO_BIT]) |=> (rstc_rdata == ($past(rstc_wdata) & 8'h0A)));

  // R4
  acpi_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_wdata == ACPI_ON_CODE) |=> (sci_en && acpi_on_stb && !smi_pulse));

  // R4
  acpi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_wdata == ACPI_OFF_CODE) |=> (!sci_en && acpi_off_stb && !smi_pulse));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmcon_rdata[LOCK_BIT] |=> (pmcon_rdata[LOCK_BIT] && $stable(smien_rdata[0])));

  // R8
  smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(apm_wr));
endmodule

// File: tb/test_pm_smi_rst_ctrl.sv
module test_pm_smi_rst_ctrl;
  localparam logic [7:0] ON_C  = 8'h96;
  localparam logic [7:0] OFF_C = 8'h69;
  localparam logic [31:0] MASK = 32'h0000_FF80;

  logic clk = 0, rst_n = 0;
  logic rstc_wr = 0, apm_wr = 0, smien_wr = 0, pmcon_wr = 0;
  logic [7:0] rstc_wdata = 0, apm_wdata = 0;
  logic [31:0] smien_wdata = 0, pmbase_wdata = 0;
  logic [15:0] pmcon_wdata = 0;
  logic [3:0] pmbase_be = 0;
  logic [7:0] rstc_rdata;
  logic [31:0] smien_rdata, pmbase;
  logic [15:0] pmcon_rdata;
  logic sys_rst_req, smi_pulse, sci_en, acpi_on_stb, acpi_off_stb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pm_smi_rst_ctrl #(.ACPI_ON_CODE(ON_C), .ACPI_OFF_CODE(OFF_C)) i_pm_smi_rst_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rstc_wr(rstc_wr), .rstc_wdata(rstc_wdata), .rstc_rdata(rstc_rdata), .sys_rst_req(sys_rst_req),
    .apm_wr(apm_wr), .apm_wdata(apm_wdata),
    .smien_wr(smien_wr), .smien_wdata(smien_wdata), .smien_rdata(smien_rdata),
    .pmcon_wr(pmcon_wr), .pmcon_wdata(pmcon_wdata), .pmcon_rdata(pmcon_rdata),
    .pmbase_be(pmbase_be), .pmbase_wdata(pmbase_wdata), .pmbase(pmbase),
    .smi_pulse(smi_pulse), .sci_en(sci_en), .acpi_on_stb(acpi_on_stb), .acpi_off_stb(acpi_off_stb));

  // behavioural reference model
  logic [7:0] m_rstc = 0;
  logic [31:0] m_smien = 0, m_base = 0;
  logic [15:0] m_pmcon = 0;
  logic m_req = 0, m_smi = 0, m_sci = 0, m_on = 0, m_off = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rstc = 0; m_smien = 0; m_base = 0; m_pmcon = 0;
      m_req = 0; m_smi = 0; m_sci = 0; m_on = 0; m_off = 0;
    end else begin
      m_req = rstc_wr && rstc_wdata[2];
      if (rstc_wr && !rstc_wdata[2]) m_rstc = rstc_wdata & 8'h0A;
      m_on  = apm_wr && apm_wdata == ON_C;
      m_off = apm_wr && apm_wdata == OFF_C;
      m_smi = apm_wr && !m_on && !m_off && m_smien[5];
      if (m_on) m_sci = 1; else if (m_off) m_sci = 0;
      if (smien_wr) begin
        if (m_pmcon[4]) m_smien = {smien_wdata[31:1], m_smien[0]};
        else m_smien = smien_wdata;
      end
      if (pmcon_wr) begin
        if (m_pmcon[4]) m_pmcon = pmcon_wdata | 16'h0010;
        else m_pmcon = pmcon_wdata;
      end
      for (int b = 0; b < 4; b++)
        if (pmbase_be[b]) m_base[8*b +: 8] = pmbase_wdata[8*b +: 8];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(rst_n ? "R1" : "R3", sys_rst_req, m_req);
    check(rst_n ? "R2" : "R3", rstc_rdata, m_rstc);
    check(rst_n ? "R4" : "R3", {sci_en, acpi_on_stb, acpi_off_stb}, {m_sci, m_on, m_off});
    check(rst_n ? "R5 R8" : "R3", smi_pulse, m_smi);
    check(rst_n ? "R6" : "R3", smien_rdata, m_smien);
    check(rst_n ? "R6" : "R3", pmcon_rdata, m_pmcon);
    check(rst_n ? "R7" : "R3", pmbase, m_base & MASK);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic w_rstc(logic [7:0] v);
    @(negedge clk); rstc_wr = 1; rstc_wdata = v; @(negedge clk); rstc_wr = 0;
  endtask
  task automatic w_apm(logic [7:0] v);
    @(negedge clk); apm_wr = 1; apm_wdata = v; @(negedge clk); apm_wr = 0;
  endtask
  task automatic w_smien(logic [31:0] v);
    @(negedge clk); smien_wr = 1; smien_wdata = v; @(negedge clk); smien_wr = 0;
  endtask
  task automatic w_pmcon(logic [15:0] v);
    @(negedge clk); pmcon_wr = 1; pmcon_wdata = v; @(negedge clk); pmcon_wr = 0;
  endtask
  task automatic w_base(logic [3:0] be, logic [31:0] v);
    @(negedge clk); pmbase_be = be; pmbase_wdata = v; @(negedge clk); pmbase_be = 0;
  endtask
  task automatic do_reset();
    @(negedge clk); #1 rst_n = 0;
    idle(3);
    #1 rst_n = 1;
  endtask

  initial begin
    idle(4);                                  // R3 reset state
    #1 rst_n = 1;
    idle(2);
    w_rstc(8'hFF); idle(1);                   // R1 go bit, nothing stored
    w_rstc(8'hFB); idle(1);                   // R2 keeps 0x0A
    w_rstc(8'h04); idle(1);                   // R1 stored value unchanged
    w_rstc(8'h02); idle(1);                   // R2
    w_apm(8'h10); idle(1);                    // R5 enable bit clear: no SMI
    w_smien(32'h0000_0020);
    w_apm(8'h10); idle(1);                    // R5 SMI
    w_apm(ON_C); idle(1);                     // R4 on, no SMI
    w_apm(8'hF0); idle(1);                    // R5 default code is ordinary here
    w_apm(OFF_C); idle(1);                    // R4 off
    @(negedge clk); apm_wr = 1; apm_wdata = 8'h22;
    @(negedge clk); apm_wdata = 8'h33;        // R8 back-to-back pulses
    @(negedge clk); apm_wr = 0; idle(2);
    w_smien(32'hFFFF_FFFF);
    w_pmcon(16'h0010); idle(1);               // R6 lock
    w_smien(32'h0000_0000); idle(1);          // R6 bit 0 frozen
    w_pmcon(16'h0000); idle(1);               // R6 lock stays
    w_pmcon(16'hABCD); idle(1);               // R6 other bits writable
    w_apm(8'h44); idle(1);                    // R5 enable now clear
    w_base(4'b1111, 32'h1234_5678); idle(1);  // R7
    w_base(4'b0010, 32'hAAAA_CDEF); idle(1);  // R7 one byte
    w_base(4'b0001, 32'hFFFF_FFFF); idle(1);  // R7 masked low bits
    w_base(4'b0000, 32'h0000_0000); idle(1);  // R7 no enables
    do_reset(); idle(1);                      // R3
    w_smien(32'h0); w_pmcon(16'h0); idle(2);  // R6 freeze lifted
    w_rstc(8'h0A); idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule